// File: doc/BRIEF.md
# Configurable Byte-Order Buffer Serializer

This block takes 64-bit double-words fetched from a memory buffer and hands their eight bytes, one per handshake, to a serial transmitter. A 2-bit ordering mode selects the sequence. In big-endian mode the most significant byte goes out first. In double-word little-endian mode the least significant byte of the double-word goes out first. In swapped mode the bytes within each 32-bit word go out in the reverse of the big-endian order.

The mode is not used directly. It is captured into an active-mode register on a descriptor-start strobe, so that a new buffer descriptor can change the order without disturbing a buffer already being emitted. Swapped mode is allowed only on a 32-bit memory port. If it is requested with a narrower port, the block raises a sticky error flag and emits that buffer in big-endian order.

Top module: `byte_order_serializer`

## Requirements
- R1: After a synchronous reset, byte_valid is 0, dw_ready is 1 and order_err is 0. A word sent before any descriptor start is emitted in big-endian order.
- R2: With active mode 2'b10 or 2'b11 (big-endian), the eight bytes of a word leave in the order dw_data[63:56], [55:48], and so on down to [7:0].
- R3: With active mode 2'b01 (double-word little-endian), the bytes leave in the order dw_data[7:0], [15:8], and so on up to [63:56].
- R4: With active mode 2'b00 (swapped) and a 32-bit port, the byte lanes leave in the order 4,5,6,7,0,1,2,3, where lane k is dw_data[8k+7:8k].
- R5: If desc_start is accepted while order_mode is 2'b00 and port_is32 is 0, order_err goes to 1 at that clock edge and big-endian order is used. Once set, order_err stays 1 until reset.
- R6: The active mode is loaded from order_mode only on a clock edge where desc_start is 1. At any other edge a change of order_mode has no effect on the emitted order.
- R7: A desc_start that arrives while a word is still being emitted is ignored, both for that word and for the words after it.
- R8: While a word is held, dw_ready is 0. While byte_valid is 1 and byte_ready is 0, byte_data stays stable and byte_valid stays 1.
- R9: Each accepted word yields exactly eight byte handshakes. In the cycle after the eighth handshake, byte_valid is 0 and dw_ready is 1.
- R10: A desc_start in the same cycle as a word is accepted applies its mode to that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dw_valid | input | 1 | Double-word offered |
| dw_ready | output | 1 | Block can accept a double-word |
| dw_data | input | 64 | Buffer double-word |
| port_is32 | input | 1 | 1 when the memory port is 32 bits wide |
| order_mode | input | 2 | Requested byte-ordering mode |
| desc_start | input | 1 | Start of a new buffer descriptor |
| byte_valid | output | 1 | Output byte valid |
| byte_ready | input | 1 | Transmitter takes the byte |
| byte_data | output | 8 | Output byte |
| order_err | output | 1 | Sticky illegal mode/port-size flag |

## Verification
A word accepted at one clock edge shows its first byte on byte_data right after that edge. Each later byte appears right after the edge that completes the previous handshake, and dw_ready returns one cycle after the eighth handshake. The error flag and the new active mode take effect at the edge where desc_start is sampled. The bench drives inputs and samples outputs on the falling edge, so every check reads the state settled by the preceding rising edge. Random stalls on byte_ready test that bytes hold steady and that the expected sequence, taken from a bench function of mode and byte position, only advances on a completed handshake.

// File: rtl/byte_order_serializer.sv
module byte_order_serializer (
  input  logic        clk,
  input  logic        rst,
  input  logic        dw_valid,
  output logic        dw_ready,
  input  logic [63:0] dw_data,
  input  logic        port_is32,
  input  logic [1:0]  order_mode,
  input  logic        desc_start,
  output logic        byte_valid,
  input  logic        byte_ready,
  output logic [7:0]  byte_data,
  output logic        order_err
);
  localparam logic [1:0] MODE_BIG = 2'b10;

  logic [63:0] hold;
  logic [2:0]  cnt;
  logic [2:0]  idx;
  logic        busy;
  logic [1:0]  act_mode;
  logic        err;

  wire take = dw_valid && !busy;
  wire give = busy && byte_ready;

  assign dw_ready   = !busy;
  assign byte_valid = busy;
  assign order_err  = err;

  always_comb begin
    if (act_mode[1])      idx = ~cnt;
    else if (act_mode[0]) idx = cnt;
    else                  idx = cnt ^ 3'd4;
  end

  assign byte_data = hold[{idx, 3'b000} +: 8];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= 3'd0;
      busy     <= 1'b0;
      act_mode <= MODE_BIG;
      err      <= 1'b0;
      hold     <= 64'd0;
    end else begin
      if (desc_start && !busy) begin
        if (order_mode == 2'b00 && !port_is32) begin
          act_mode <= MODE_BIG;
          err      <= 1'b1;
        end else begin
          act_mode <= order_mode;
        end
      end
      if (take) begin
        hold <= dw_data;
        busy <= 1'b1;
        cnt  <= 3'd0;
      end else if (give) begin
        cnt <= cnt + 3'd1;
        if (cnt == 3'd7) busy <= 1'b0;
      end
    end
  end
endmodule

module byte_order_serializer_chk (
  input logic       clk,
  input logic       rst,
  input logic       dw_ready,
  input logic       byte_valid,
  input logic       byte_ready,
  input logic [7:0] byte_data,
  input logic       order_err,
  input logic       desc_start,
  input logic [1:0] act_mode,
  input logic [2:0] cnt
);
  a_r8_no_accept_busy: assert property (@(posedge clk) disable iff (rst)
    byte_valid |-> !dw_ready);

  a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && !byte_ready) |=> (byte_valid && $stable(byte_data)));

  a_r5_err_sticky: assert property (@(posedge clk) disable iff (rst)
    order_err |=> order_err);

  a_r6_mode_held: assert property (@(posedge clk) disable iff (rst)
    !desc_start |=> $stable(act_mode));

  a_r9_eight_bytes: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_ready && cnt == 3'd7) |=> (!byte_valid && dw_ready));

  a_r9_continue: assert property (@(posedge clk) disable iff (rst)
    (byte_valid && byte_ready && cnt != 3'd7) |=> byte_valid);
endmodule

bind byte_order_serializer byte_order_serializer_chk u_chk (
  .clk(clk), .rst(rst), .dw_ready(dw_ready), .byte_valid(byte_valid),
  .byte_ready(byte_ready), .byte_data(byte_data), .order_err(order_err),
  .desc_start(desc_start), .act_mode(act_mode), .cnt(cnt)
);

// File: tb/sim_byte_order_serializer.sv
module sim_byte_order_serializer;
  logic        clk = 0;
  logic        rst = 1;
  logic        dw_valid = 0;
  logic        dw_ready;
  logic [63:0] dw_data = '0;
  logic        port_is32 = 1;
  logic [1:0]  order_mode = 2'b10;
  logic        desc_start = 0;
  logic        byte_valid;
  logic        byte_ready = 0;
  logic [7:0]  byte_data;
  logic        order_err;

  int checks = 0;
  int fails = 0;
  logic [1:0] m_mode = 2'b10;
  logic       m_err = 0;

  always #5 clk = ~clk;

  byte_order_serializer u0 (
    .clk(clk), .rst(rst), .dw_valid(dw_valid), .dw_ready(dw_ready),
    .dw_data(dw_data), .port_is32(port_is32), .order_mode(order_mode),
    .desc_start(desc_start), .byte_valid(byte_valid), .byte_ready(byte_ready),
    .byte_data(byte_data), .order_err(order_err)
  );

  function automatic logic [7:0] exp_byte(logic [63:0] d, logic [1:0] m, int i);
    int lane;
    if (m[1])      lane = 7 - i;
    else if (m[0]) lane = i;
    else           lane = i ^ 4;
    return d[lane*8 +: 8];
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_desc(logic [1:0] m, logic p);
    if (m == 2'b00 && !p) begin m_mode = 2'b10; m_err = 1; end
    else m_mode = m;
  endtask

  task automatic start_desc(logic [1:0] m, logic p);
    @(negedge clk);
    order_mode = m; port_is32 = p; desc_start = 1;
    @(negedge clk);
    desc_start = 0;
    model_desc(m, p);
    chk(order_err == m_err, "R5 err flag", order_err, m_err);
  endtask

  task automatic send_word(logic [63:0] d, string tag, bit mid_desc, bit with_desc,
                           logic [1:0] dm, logic dp);
    logic [1:0] em;
    @(negedge clk);
    dw_valid = 1; dw_data = d;
    if (with_desc) begin order_mode = dm; port_is32 = dp; desc_start = 1; end
    @(negedge clk);
    dw_valid = 0; desc_start = 0;
    if (with_desc) model_desc(dm, dp);
    em = m_mode;
    chk(dw_ready == 0, "R8 ready low while held", dw_ready, 0);
    for (int i = 0; i < 8; i++) begin
      bit done = 0;
      while (!done) begin
        byte_ready = ($urandom % 3) != 0;
        if (mid_desc && i == 3) begin
          order_mode = ~em; port_is32 = 0; desc_start = 1;
        end
        chk(byte_valid == 1, "R8 valid while held", byte_valid, 1);
        chk(byte_data == exp_byte(d, em, i), tag, byte_data, exp_byte(d, em, i));
        done = byte_ready;
        @(negedge clk);
        desc_start = 0;
      end
    end
    byte_ready = 0;
    chk(byte_valid == 0 && dw_ready == 1, "R9 idle after eight",
        {byte_valid, dw_ready}, 2'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst = 0;
    chk(byte_valid == 0 && dw_ready == 1 && order_err == 0, "R1 reset state",
        {byte_valid, dw_ready, order_err}, 3'b010);
    send_word(64'h0011_2233_4455_6677, "R1 default big-endian", 0, 0, 0, 0);

    start_desc(2'b11, 1);
    send_word(64'h8877_6655_4433_2211, "R2 big-endian", 0, 0, 0, 0);
    start_desc(2'b01, 0);
    send_word(64'hA1B2_C3D4_E5F6_0718, "R3 dword little-endian", 0, 0, 0, 0);
    start_desc(2'b00, 1);
    chk(order_err == 0, "R4 legal swap no error", order_err, 0);
    send_word(64'h0102_0304_0506_0708, "R4 swapped", 0, 0, 0, 0);

    @(negedge clk); order_mode = 2'b01;
    send_word(64'hDEAD_BEEF_0BAD_F00D, "R6 mode change without strobe", 0, 0, 0, 0);

    send_word(64'h1357_9BDF_2468_ACE0, "R7 strobe mid-word", 1, 0, 0, 0);
    send_word(64'hFEDC_BA98_7654_3210, "R7 after ignored strobe", 0, 0, 0, 0);

    send_word(64'h0F1E_2D3C_4B5A_6978, "R10 strobe with word", 0, 1, 2'b01, 1);

    start_desc(2'b00, 0);
    send_word(64'hC0C1_C2C3_C4C5_C6C7, "R5 fallback big-endian", 0, 0, 0, 0);
    start_desc(2'b01, 1);
    chk(order_err == 1, "R5 sticky", order_err, 1);

    for (int n = 0; n < 40; n++) begin
      logic [63:0] d;
      d = {$urandom, $urandom};
      if ($urandom % 2) start_desc(2'($urandom % 4), 1'($urandom % 2));
      send_word(d, "R2 R3 R4 random order", 0, 0, 0, 0);
    end

    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    m_err = 0; m_mode = 2'b10;
    chk(order_err == 0 && byte_valid == 0, "R1 reset clears error",
        {order_err, byte_valid}, 2'b00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule